// File: doc/BRIEF.md
# Li-Ion Charge Sequencer

This block is the digital controller of a single-cell lithium-ion charger. Comparator results from the analog front end come in as single-bit flags: input voltage above its lower limit and below its upper limit, adaptor present, battery past the pre-charge threshold, battery at regulation voltage, charge current under the end-of-charge level, battery sagged to the restart level, thermistor inside its window, thermistor pin pulled to the bias rail, and enable. From these flags the block walks the charge through a trickle phase, a constant-current phase, a constant-voltage phase and a maintenance phase. It drives a phase code, the enables of the current and voltage loops, and two active-low status LED outputs.

Every flag passes through a two-flop synchronizer and a stability filter before the sequencer acts on it. A safety timer counts an external 1 Hz tick only while the constant-current phase is active. If the timer reaches its terminal count, the block latches a fault. A thermistor excursion pauses charging, and when the temperature returns the flow starts again from the trickle phase. When the thermistor pin sits at the rail, the block enters a regulated-output test mode, and no charge cycle runs in that mode.

Top module: `li_chg_seq`

## Requirements
- R1: After reset, phase_o is 0 (idle), both LED outputs are 1 (off), and trickle_en_o, i_loop_en_o and v_loop_en_o are 0.
- R2: The block leaves idle only when uv_ok_i, ov_ok_i, adp_ok_i and enable_i are all 1 and ldo_det_i is 0. It then enters pre-charge, phase code 1, in which trickle_en_o and i_loop_en_o are both 1.
- R3: Pre-charge moves to constant current (phase 2, i_loop_en_o=1, trickle_en_o=0) when batt_qual_i is 1.
- R4: Constant current moves to constant voltage (phase 3, v_loop_en_o=1 only) when batt_reg_i is 1. Constant voltage moves to maintenance (phase 4, no loop enabled) when eoc_cur_i is 1. i_loop_en_o and v_loop_en_o are never 1 together.
- R5: In maintenance, batt_low_i=1 starts a new cycle in pre-charge. Every charging phase of that new cycle shows red off and green on (red_led_n_o=1, green_led_n_o=0). Maintenance itself shows the same LED pattern.
- R6: The safety timer counts tick_1hz_i pulses only during constant current and clears in every other phase. When it reaches TIMER_TERM counts, the block enters the fault phase (6) with both LEDs on (0/0). The fault is latched until input power is lost or enable_i goes low. If the timer expires in the same cycle as batt_reg_i arrives, the fault wins.
- R7: temp_ok_i=0 during pre-charge, constant current or constant voltage moves the block to a temperature hold (phase 5): both LEDs on, all loops off. When temp_ok_i returns to 1, the block resumes at pre-charge with the safety timer cleared.
- R8: ldo_det_i=1 selects the test mode (phase 7), with v_loop_en_o=1, i_loop_en_o=0 and both LEDs off. When ldo_det_i returns to 0, the block goes back to idle, and the next cycle counts as a first charge.
- R9: enable_i=0 while input power is valid forces the disabled phase (8): loops off, red off, green on. This applies from any phase, including the test mode and the fault phase.
- R10: If any of uv_ok_i, ov_ok_i or adp_ok_i is 0, the block returns to idle from any phase. This clears the fault and the recharge marking, and both LEDs turn off.
- R11: A flag change that lasts fewer than STABLE_CYC cycles after synchronization does not change the phase.
- R12: During the first charge after idle, each charging phase (1, 2, 3) shows red on and green off (red_led_n_o=0, green_led_n_o=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Input voltage above under-voltage limit |
| ov_ok_i | input | 1 | Input voltage below over-voltage limit |
| adp_ok_i | input | 1 | Adaptor headroom good |
| batt_qual_i | input | 1 | Battery above pre-charge threshold |
| batt_reg_i | input | 1 | Battery at regulation voltage |
| eoc_cur_i | input | 1 | Charge current below end-of-charge level |
| batt_low_i | input | 1 | Battery fallen to restart level |
| temp_ok_i | input | 1 | Thermistor voltage inside charge window |
| ldo_det_i | input | 1 | Thermistor pin at bias rail (test mode) |
| enable_i | input | 1 | Charger enable |
| tick_1hz_i | input | 1 | One-cycle pulse per second for the safety timer |
| phase_o | output | 4 | Phase code |
| trickle_en_o | output | 1 | Trickle current select |
| i_loop_en_o | output | 1 | Current-regulation loop enable |
| v_loop_en_o | output | 1 | Voltage-regulation loop enable |
| red_led_n_o | output | 1 | Charging LED, active low |
| green_led_n_o | output | 1 | Done LED, active low |

## Verification
The safety-timer expiry and the arrival of the regulation-voltage flag can land in the same cycle of the constant-current phase. The bench provokes this by giving one tick fewer than the terminal count and then raising batt_reg_i. It times the last tick so that the tick reaches the counter on the same clock edge at which the filtered regulation flag goes high. The expected result is the fault phase with both LEDs on. A design that favours the voltage transition ends in constant voltage instead.

// File: rtl/li_chg_pkg.sv
package li_chg_pkg;

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_PREQ  = 4'd1,
        PH_CC    = 4'd2,
        PH_CV    = 4'd3,
        PH_MAINT = 4'd4,
        PH_THOLD = 4'd5,
        PH_FAULT = 4'd6,
        PH_LDO   = 4'd7,
        PH_OFF   = 4'd8
    } phase_e;

    localparam int NFLAG  = 10;
    localparam int F_UV   = 0;
    localparam int F_OV   = 1;
    localparam int F_ADP  = 2;
    localparam int F_QUAL = 3;
    localparam int F_REG  = 4;
    localparam int F_EOC  = 5;
    localparam int F_LOW  = 6;
    localparam int F_TEMP = 7;
    localparam int F_LDO  = 8;
    localparam int F_EN   = 9;

    typedef struct packed {
        phase_e phase;
        logic   recharge;
    } seq_st_t;

endpackage

// File: rtl/li_chg_flag_cond.sv
module li_chg_flag_cond #(
    parameter int W           = 10,
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] flt_o
);
    localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);

    logic [SYNC_STAGES-1:0][W-1:0] sync_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[s] <= '0;
            end else if (s == 0) begin
                sync_q[s] <= raw_i;
            end else begin
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CW-1:0] cnt_d, cnt_q;
        logic          flt_d, flt_q;
        logic          s_val;

        assign s_val = sync_q[SYNC_STAGES-1][b];

        always_comb begin
            cnt_d = '0;
            flt_d = flt_q;
            if (s_val != flt_q) begin
                if (cnt_q == CW'(STABLE_CYC - 1)) begin
                    flt_d = s_val;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                flt_q <= 1'b0;
            end else begin
                cnt_q <= cnt_d;
                flt_q <= flt_d;
            end
        end

        assign flt_o[b] = flt_q;
    end

endmodule

// File: rtl/li_chg_safety_tmr.sv
module li_chg_safety_tmr #(
    parameter int TERM = 20160,
    parameter int CW   = $clog2(TERM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != CW'(TERM))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign expired_o = (cnt_q == CW'(TERM));

endmodule

// File: rtl/li_chg_status_dec.sv
module li_chg_status_dec
    import li_chg_pkg::*;
(
    input  phase_e phase_i,
    input  logic   recharge_i,
    output logic   trickle_en_o,
    output logic   i_loop_en_o,
    output logic   v_loop_en_o,
    output logic   red_n_o,
    output logic   green_n_o
);
    always_comb begin
        trickle_en_o = 1'b0;
        i_loop_en_o  = 1'b0;
        v_loop_en_o  = 1'b0;
        red_n_o      = 1'b1;
        green_n_o    = 1'b1;
        unique case (phase_i)
            PH_PREQ, PH_CC, PH_CV: begin
                trickle_en_o = (phase_i == PH_PREQ);
                i_loop_en_o  = (phase_i != PH_CV);
                v_loop_en_o  = (phase_i == PH_CV);
                red_n_o      = recharge_i;
                green_n_o    = !recharge_i;
            end
            PH_MAINT, PH_OFF: begin
                green_n_o = 1'b0;
            end
            PH_THOLD, PH_FAULT: begin
                red_n_o   = 1'b0;
                green_n_o = 1'b0;
            end
            PH_LDO: begin
                v_loop_en_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/li_chg_seq.sv
module li_chg_seq
    import li_chg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 16,
    parameter int TIMER_TERM  = 20160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_ok_i,
    input  logic       ov_ok_i,
    input  logic       adp_ok_i,
    input  logic       batt_qual_i,
    input  logic       batt_reg_i,
    input  logic       eoc_cur_i,
    input  logic       batt_low_i,
    input  logic       temp_ok_i,
    input  logic       ldo_det_i,
    input  logic       enable_i,
    input  logic       tick_1hz_i,
    output logic [3:0] phase_o,
    output logic       trickle_en_o,
    output logic       i_loop_en_o,
    output logic       v_loop_en_o,
    output logic       red_led_n_o,
    output logic       green_led_n_o
);
    localparam int TMR_W = $clog2(TIMER_TERM + 1);

    logic [NFLAG-1:0] raw, flt;
    logic             pwr_ok;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_exp;
    seq_st_t          st_d, st_q;

    always_comb begin
        raw         = '0;
        raw[F_UV]   = uv_ok_i;
        raw[F_OV]   = ov_ok_i;
        raw[F_ADP]  = adp_ok_i;
        raw[F_QUAL] = batt_qual_i;
        raw[F_REG]  = batt_reg_i;
        raw[F_EOC]  = eoc_cur_i;
        raw[F_LOW]  = batt_low_i;
        raw[F_TEMP] = temp_ok_i;
        raw[F_LDO]  = ldo_det_i;
        raw[F_EN]   = enable_i;
    end

    li_chg_flag_cond #(
        .W           (NFLAG),
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (STABLE_CYC)
    ) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .flt_o (flt)
    );

    li_chg_safety_tmr #(
        .TERM (TIMER_TERM),
        .CW   (TMR_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.phase == PH_CC),
        .tick_i    (tick_1hz_i),
        .cnt_o     (tmr_cnt),
        .expired_o (tmr_exp)
    );

    assign pwr_ok = flt[F_UV] & flt[F_OV] & flt[F_ADP];

    always_comb begin
        st_d = st_q;
        if (!pwr_ok) begin
            st_d.phase    = PH_IDLE;
            st_d.recharge = 1'b0;
        end else if (!flt[F_EN]) begin
            st_d.phase    = PH_OFF;
            st_d.recharge = 1'b0;
        end else if (st_q.phase == PH_FAULT) begin
            st_d = st_q;
        end else if (flt[F_LDO]) begin
            st_d.phase    = PH_LDO;
            st_d.recharge = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE, PH_OFF: begin
                    st_d.phase = (st_q.phase == PH_IDLE) ? PH_PREQ : PH_IDLE;
                end
                PH_LDO: begin
                    st_d.phase = PH_IDLE;
                end
                PH_PREQ: begin
                    if (!flt[F_TEMP])     st_d.phase = PH_THOLD;
                    else if (flt[F_QUAL]) st_d.phase = PH_CC;
                end
                PH_CC: begin
                    if (!flt[F_TEMP])    st_d.phase = PH_THOLD;
                    else if (tmr_exp)    st_d.phase = PH_FAULT;
                    else if (flt[F_REG]) st_d.phase = PH_CV;
                end
                PH_CV: begin
                    if (!flt[F_TEMP])    st_d.phase = PH_THOLD;
                    else if (flt[F_EOC]) st_d.phase = PH_MAINT;
                end
                PH_MAINT: begin
                    if (flt[F_LOW]) begin
                        st_d.phase    = PH_PREQ;
                        st_d.recharge = 1'b1;
                    end
                end
                PH_THOLD: begin
                    if (flt[F_TEMP]) st_d.phase = PH_PREQ;
                end
                default: begin
                    st_d.phase    = PH_IDLE;
                    st_d.recharge = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, recharge: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    li_chg_status_dec u_dec (
        .phase_i      (st_q.phase),
        .recharge_i   (st_q.recharge),
        .trickle_en_o (trickle_en_o),
        .i_loop_en_o  (i_loop_en_o),
        .v_loop_en_o  (v_loop_en_o),
        .red_n_o      (red_led_n_o),
        .green_n_o    (green_led_n_o)
    );

    assign phase_o = st_q.phase;

endmodule

// File: rtl/li_chg_seq_chk.sv
module li_chg_seq_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       phase,
    input logic             pwr_ok,
    input logic             en_ok,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic             tmr_exp,
    input logic             i_loop,
    input logic             v_loop,
    input logic             red_n,
    input logic             grn_n
);
    localparam logic [3:0] P_IDLE  = 4'd0;
    localparam logic [3:0] P_CC    = 4'd2;
    localparam logic [3:0] P_FAULT = 4'd6;
    localparam logic [3:0] P_LDO   = 4'd7;
    localparam logic [3:0] P_OFF   = 4'd8;

    assert_power_loss_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> phase == P_IDLE);

    assert_enable_low_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !en_ok) |=> phase == P_OFF);

    assert_off_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == P_OFF |-> (!i_loop && !v_loop && red_n && !grn_n));

    assert_fault_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_FAULT && pwr_ok && en_ok) |=> phase == P_FAULT);

    assert_fault_leds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == P_FAULT |-> (!red_n && !grn_n && !i_loop && !v_loop));

    assert_timer_cc_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase != P_CC |=> tmr_cnt == '0);

    assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_FAULT && $past(phase) != P_FAULT) |-> ($past(tmr_exp) && $past(phase) == P_CC));

    assert_loops_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_loop, v_loop}));

    assert_ldo_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == P_LDO |-> (v_loop && !i_loop && red_n && grn_n));

endmodule

bind li_chg_seq li_chg_seq_chk #(.CNT_W(TMR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_o),
    .pwr_ok  (pwr_ok),
    .en_ok   (flt[9]),
    .tmr_cnt (tmr_cnt),
    .tmr_exp (tmr_exp),
    .i_loop  (i_loop_en_o),
    .v_loop  (v_loop_en_o),
    .red_n   (red_led_n_o),
    .grn_n   (green_led_n_o)
);

// File: tb/li_chg_seq_tb.sv
module li_chg_seq_tb;
    localparam int STABLE = 4;
    localparam int TERM   = 8;
    localparam int SETTLE = 16;

    localparam logic [3:0] P_IDLE = 0, P_PREQ = 1, P_CC = 2, P_CV = 3, P_MAINT = 4,
                           P_THOLD = 5, P_FAULT = 6, P_LDO = 7, P_OFF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 0, ov = 0, adp = 0, qual = 0, reg_v = 0, eoc = 0, low = 0;
    logic temp = 0, ldo = 0, en = 0, tick = 0;
    logic [3:0] phase;
    logic trickle, iloop, vloop, red_n, grn_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    li_chg_seq #(
        .SYNC_STAGES (2),
        .STABLE_CYC  (STABLE),
        .TIMER_TERM  (TERM)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .uv_ok_i (uv), .ov_ok_i (ov), .adp_ok_i (adp),
        .batt_qual_i (qual), .batt_reg_i (reg_v), .eoc_cur_i (eoc),
        .batt_low_i (low), .temp_ok_i (temp), .ldo_det_i (ldo),
        .enable_i (en), .tick_1hz_i (tick),
        .phase_o (phase), .trickle_en_o (trickle), .i_loop_en_o (iloop),
        .v_loop_en_o (vloop), .red_led_n_o (red_n), .green_led_n_o (grn_n)
    );

    typedef struct {
        logic [3:0] ph;
        bit         rech;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;

    task automatic expect_ph(input logic [3:0] ph, input bit rech, input string tag);
        exp_t it;
        it.ph = ph; it.rech = rech; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    // scoreboard monitor: expected LED and loop values follow the requirement encodings
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [6:0] exp_v, act_v;
                logic e_tr, e_il, e_vl, e_r, e_g;
                it = sb_q.pop_front();
                e_tr = (it.ph == P_PREQ);
                e_il = (it.ph == P_PREQ) || (it.ph == P_CC);
                e_vl = (it.ph == P_CV) || (it.ph == P_LDO);
                case (it.ph)
                    P_PREQ, P_CC, P_CV: begin e_r = it.rech; e_g = !it.rech; end
                    P_MAINT, P_OFF:     begin e_r = 1'b1; e_g = 1'b0; end
                    P_THOLD, P_FAULT:   begin e_r = 1'b0; e_g = 1'b0; end
                    default:            begin e_r = 1'b1; e_g = 1'b1; end
                endcase
                exp_v = {it.ph, e_tr, e_il, e_vl};
                act_v = {phase, trickle, iloop, vloop};
                n_cmp++;
                if (exp_v !== act_v || e_r !== red_n || e_g !== grn_n) begin
                    n_bad++;
                    $display("FAIL %s: phase/tr/il/vl=%h red_n=%b grn_n=%b expected %h red_n=%b grn_n=%b",
                             it.tag, act_v, red_n, grn_n, exp_v, e_r, e_g);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_ph(P_IDLE, 0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        uv = 1; ov = 1; temp = 1; en = 1;
        settle();
        expect_ph(P_IDLE, 0, "R2 no start without adaptor");
        adp = 1;
        settle();
        expect_ph(P_PREQ, 0, "R2 R12 pre-charge first charge");
        ticks(10);
        // short glitch on qualification flag
        @(negedge clk) qual = 1;
        repeat (STABLE - 1) @(negedge clk);
        qual = 0;
        settle();
        expect_ph(P_PREQ, 0, "R11 short glitch ignored");
        qual = 1;
        settle();
        expect_ph(P_CC, 0, "R3 R12 constant current");
        ticks(5);
        temp = 0;
        settle();
        expect_ph(P_THOLD, 0, "R7 temperature hold");
        qual = 0;
        settle();
        temp = 1;
        settle();
        expect_ph(P_PREQ, 0, "R7 resume at pre-charge");
        qual = 1;
        settle();
        ticks(TERM - 1);
        settle();
        expect_ph(P_CC, 0, "R6 R7 timer cleared, ticks outside CC ignored");
        ticks(1);
        settle();
        expect_ph(P_FAULT, 0, "R6 timer expiry fault");
        temp = 0; ldo = 1;
        settle();
        expect_ph(P_FAULT, 0, "R6 fault latched");
        temp = 1; ldo = 0;
        adp = 0;
        settle();
        expect_ph(P_IDLE, 0, "R10 power loss clears fault");
        adp = 1;
        settle();
        expect_ph(P_CC, 0, "R10 R3 restart after power return");
        ticks(TERM - 1);
        // timer expiry and regulation flag in the same cycle
        @(negedge clk) reg_v = 1;
        repeat (STABLE + 1) @(negedge clk);
        tick = 1;
        @(negedge clk) tick = 0;
        settle();
        expect_ph(P_FAULT, 0, "R6 expiry beats regulation flag");
        en = 0;
        settle();
        expect_ph(P_OFF, 0, "R9 enable low from fault");
        en = 1;
        settle();
        expect_ph(P_CV, 0, "R4 constant voltage");
        eoc = 1;
        settle();
        expect_ph(P_MAINT, 0, "R4 R5 maintenance");
        qual = 0; reg_v = 0; eoc = 0;
        settle();
        expect_ph(P_MAINT, 0, "R5 maintenance holds");
        low = 1;
        settle();
        expect_ph(P_PREQ, 1, "R5 recharge pre-charge");
        low = 0; qual = 1;
        settle();
        expect_ph(P_CC, 1, "R5 recharge constant current");
        ldo = 1;
        settle();
        expect_ph(P_LDO, 0, "R8 test mode");
        en = 0;
        settle();
        expect_ph(P_OFF, 0, "R9 enable low from test mode");
        en = 1;
        settle();
        expect_ph(P_LDO, 0, "R8 test mode after enable");
        ldo = 0;
        settle();
        expect_ph(P_CC, 0, "R8 R12 first charge after test mode");
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule